// File: doc/BRIEF.md
# Calendar Clock with Year Register

This block keeps wall-clock time for a chip. It runs from a single 32.768 kHz clock, which also clocks its small register bus. A prescaler whose divide ratio is set through a trim register turns that clock into a one-second tick. Each tick advances a packed 32-bit time word (month, day, hour, minute and second) and, when December ends, a separate 32-bit year register. Month lengths follow the Gregorian leap-year rules.

Software sets the time, the year and the trim value by writing to them. Each write is a transfer that lasts a fixed number of clock cycles. During that time a busy flag in the control word stays set. Software polls that flag before it writes again, because the block drops a write that arrives while the flag is set. The read registers always return the live count. When a time load completes it restarts the prescaler, so the first tick after a load comes one full tick period later.

Top module: `tod_calendar`

## Requirements
- R1: After reset the trim value is 32767, the time word is 0x04200000 (January 1, 00:00:00), the year is 1900, and control bits 0 and 4 are clear.
- R2: Reads are decoded by address: 0x00 trim, 0x0C live time word, 0x10 live year, 0x40 control. Writes go to 0x00 trim, 0x04 time and 0x08 year. Any other read address returns zero.
- R3: The time word packs second in bits [9:4], minute in [15:10], hour in [20:16], day in [25:21] and month in [31:26]. Bits [3:0] always read zero, whatever was written to them.
- R4: A write to 0x04 or 0x08 sets control bit 0 for exactly 4 cycles, starting at the accepting edge. The new value takes effect at the edge where the bit clears, and the old value stays readable until then.
- R5: A write to 0x00 sets control bit 4 for exactly 4 cycles. The new trim value takes effect when the bit clears.
- R6: A time or year write that arrives while bit 0 is set is dropped, and so is a trim write that arrives while bit 4 is set. Time and year writes share bit 0.
- R7: With trim value T, one tick occurs every T+1 cycles.
- R8: A completed time load restarts the prescaler. The first tick after the load comes exactly T+1 cycles after the loading edge.
- R9: Second and minute wrap from 59 to 0 with a carry, and hour wraps from 23 to 0 with a carry.
- R10: Day runs from 1 up to the length of the month and then wraps to 1 with a carry. February has 29 days in years divisible by 4, except centuries that are not divisible by 400.
- R11: Month runs from 1 to 12. Leaving December sets month 1 and increments the year.
- R12: Once reset is released, control bits 5 (oscillator running) and 8 (counter enabled) read 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz clock for the counter and the bus |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The hardest cases to reach are the ones where a whole chain of carries must fire on a single tick: a year end, a February end in a century year, and a 2400-style leap century. At the real trim value these would take hours or days of simulated time. The stimulus therefore sets trim to 3 first. It loads each corner time one second before the boundary and relies on the prescaler restart after each load, so the boundary tick lands on a known cycle. Dropped writes are produced by issuing a second write on the cycle right after the first has been accepted.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int WORD_W = 32;
    localparam int YEAR_W = 32;

    localparam logic [7:0] OFS_TRIM     = 8'h00;
    localparam logic [7:0] OFS_TIME_SET = 8'h04;
    localparam logic [7:0] OFS_YEAR_SET = 8'h08;
    localparam logic [7:0] OFS_TIME_GET = 8'h0C;
    localparam logic [7:0] OFS_YEAR_GET = 8'h10;
    localparam logic [7:0] OFS_CTRL     = 8'h40;

    localparam int CB_TY_BUSY = 0;
    localparam int CB_TR_BUSY = 4;
    localparam int CB_OSC_RUN = 5;
    localparam int CB_CNT_ON  = 8;

    typedef struct packed {
        logic [5:0] month;
        logic [4:0] day;
        logic [4:0] hour;
        logic [5:0] minute;
        logic [5:0] second;
        logic [3:0] frac;
    } cal_time_t;

    typedef struct packed {
        cal_time_t          t;
        logic [YEAR_W-1:0]  year;
    } cal_state_t;

    localparam cal_time_t TIME_RESET = '{month: 6'd1, day: 5'd1, hour: 5'd0,
                                         minute: 6'd0, second: 6'd0, frac: 4'd0};
    localparam logic [YEAR_W-1:0] YEAR_RESET = YEAR_W'(1900);

    function automatic logic is_leap(input logic [YEAR_W-1:0] y);
        logic div4, div100, div400;
        div4   = (y[1:0] == 2'b00);
        div100 = ((y % YEAR_W'(100)) == '0);
        div400 = ((y % YEAR_W'(400)) == '0);
        return (div4 && !div100) || div400;
    endfunction

    function automatic logic [4:0] month_len(input logic [5:0] mo, input logic leap);
        logic [4:0] len;
        case (mo)
            6'd2:                      len = leap ? 5'd29 : 5'd28;
            6'd4, 6'd6, 6'd9, 6'd11:   len = 5'd30;
            default:                   len = 5'd31;
        endcase
        return len;
    endfunction

    function automatic cal_state_t cal_advance(input cal_state_t s);
        cal_state_t n;
        logic [4:0] last_day;
        n = s;
        last_day = month_len(s.t.month, is_leap(s.year));
        if (s.t.second >= 6'd59) begin
            n.t.second = '0;
            if (s.t.minute >= 6'd59) begin
                n.t.minute = '0;
                if (s.t.hour >= 5'd23) begin
                    n.t.hour = '0;
                    if (s.t.day >= last_day) begin
                        n.t.day = 5'd1;
                        if (s.t.month >= 6'd12) begin
                            n.t.month = 6'd1;
                            n.year    = s.year + YEAR_W'(1);
                        end else begin
                            n.t.month = s.t.month + 6'd1;
                        end
                    end else begin
                        n.t.day = s.t.day + 5'd1;
                    end
                end else begin
                    n.t.hour = s.t.hour + 5'd1;
                end
            end else begin
                n.t.minute = s.t.minute + 6'd1;
            end
        end else begin
            n.t.second = s.t.second + 6'd1;
        end
        return n;
    endfunction

endpackage

// File: rtl/tod_xfer_slot.sv
module tod_xfer_slot #(
    parameter int DW     = 32,
    parameter int CYCLES = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic [DW-1:0] req_data,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] data
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            remain <= '0;
            data   <= '0;
        end else if (!busy && req) begin
            busy   <= 1'b1;
            remain <= CW'(CYCLES);
            data   <= req_data;
        end else if (busy) begin
            remain <= remain - CW'(1);
            if (remain == CW'(1))
                busy <= 1'b0;
        end
    end

    assign done = busy && (remain == CW'(1));

endmodule

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] limit,
    input  logic         restart,
    output logic         tick,
    output logic [W-1:0] count
);
    assign tick = (count >= limit);

    always_ff @(posedge clk) begin
        if (rst || restart || tick)
            count <= '0;
        else
            count <= count + W'(1);
    end

endmodule

// File: rtl/tod_datekeeper.sv
module tod_datekeeper
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load_time,
    input  cal_time_t         time_in,
    input  logic              load_year,
    input  logic [YEAR_W-1:0] year_in,
    output cal_time_t         now,
    output logic [YEAR_W-1:0] year
);
    cal_state_t cur, stepped;

    assign cur     = '{t: now, year: year};
    assign stepped = cal_advance(cur);

    always_ff @(posedge clk) begin
        if (rst) begin
            now  <= TIME_RESET;
            year <= YEAR_RESET;
        end else begin
            if (load_time) begin
                now      <= time_in;
                now.frac <= '0;
            end else if (tick) begin
                now <= stepped.t;
            end
            if (load_year)
                year <= year_in;
            else if (tick)
                year <= stepped.year;
        end
    end

endmodule

// File: rtl/tod_calendar.sv
module tod_calendar
    import tod_pkg::*;
#(
    parameter int              PRESC_W     = 32,
    parameter int              XFER_CYCLES = 4,
    parameter logic [PRESC_W-1:0] TRIM_RESET = PRESC_W'(32767)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata
);
    localparam int TY_W = WORD_W + 1;

    logic hit_trim, hit_time, hit_year;
    assign hit_trim = bus_we && (bus_addr == OFS_TRIM);
    assign hit_time = bus_we && (bus_addr == OFS_TIME_SET);
    assign hit_year = bus_we && (bus_addr == OFS_YEAR_SET);

    logic            ty_busy, ty_done;
    logic [TY_W-1:0] ty_data;

    tod_xfer_slot #(.DW(TY_W), .CYCLES(XFER_CYCLES)) u_ty_slot (
        .clk      (clk),
        .rst      (rst),
        .req      (hit_time || hit_year),
        .req_data ({hit_year, bus_wdata}),
        .busy     (ty_busy),
        .done     (ty_done),
        .data     (ty_data)
    );

    logic               tr_busy, tr_done;
    logic [PRESC_W-1:0] tr_data;

    tod_xfer_slot #(.DW(PRESC_W), .CYCLES(XFER_CYCLES)) u_tr_slot (
        .clk      (clk),
        .rst      (rst),
        .req      (hit_trim),
        .req_data (PRESC_W'(bus_wdata)),
        .busy     (tr_busy),
        .done     (tr_done),
        .data     (tr_data)
    );

    logic [PRESC_W-1:0] trim_q;
    always_ff @(posedge clk) begin
        if (rst)
            trim_q <= TRIM_RESET;
        else if (tr_done)
            trim_q <= tr_data;
    end

    logic load_time, load_year;
    assign load_time = ty_done && !ty_data[WORD_W];
    assign load_year = ty_done &&  ty_data[WORD_W];

    logic               tick;
    logic [PRESC_W-1:0] pre_count;

    tod_prescaler #(.W(PRESC_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .limit   (trim_q),
        .restart (load_time),
        .tick    (tick),
        .count   (pre_count)
    );

    cal_time_t         now;
    logic [YEAR_W-1:0] year_now;

    tod_datekeeper u_date (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .load_time (load_time),
        .time_in   (cal_time_t'(ty_data[WORD_W-1:0])),
        .load_year (load_year),
        .year_in   (ty_data[YEAR_W-1:0]),
        .now       (now),
        .year      (year_now)
    );

    logic running;
    always_ff @(posedge clk) begin
        if (rst) running <= 1'b0;
        else     running <= 1'b1;
    end

    logic [WORD_W-1:0] ctrl_word;
    always_comb begin
        ctrl_word             = '0;
        ctrl_word[CB_TY_BUSY] = ty_busy;
        ctrl_word[CB_TR_BUSY] = tr_busy;
        ctrl_word[CB_OSC_RUN] = running;
        ctrl_word[CB_CNT_ON]  = running;
    end

    always_comb begin
        case (bus_addr)
            OFS_TRIM:     bus_rdata = WORD_W'(trim_q);
            OFS_TIME_GET: bus_rdata = now;
            OFS_YEAR_GET: bus_rdata = WORD_W'(year_now);
            OFS_CTRL:     bus_rdata = ctrl_word;
            default:      bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tod_calendar_chk.sv
module tod_calendar_chk
    import tod_pkg::*;
#(
    parameter int PRESC_W     = 32,
    parameter int XFER_CYCLES = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [7:0]         bus_addr,
    input logic               bus_we,
    input logic               ty_busy,
    input logic               tr_busy,
    input logic               load_time,
    input logic               load_year,
    input logic               tick,
    input logic [PRESC_W-1:0] pre_count,
    input logic [5:0]         cur_sec,
    input logic [YEAR_W-1:0]  year_now
);
    localparam int RW = $clog2(XFER_CYCLES + 2);

    logic [RW-1:0] run;
    always_ff @(posedge clk) begin
        if (rst)          run <= '0;
        else if (ty_busy) run <= run + RW'(1);
        else              run <= '0;
    end

    a_r4_busy_bounded: assert property (@(posedge clk) disable iff (rst)
        run <= RW'(XFER_CYCLES));

    a_r4_busy_length: assert property (@(posedge clk) disable iff (rst)
        $fell(ty_busy) |-> run == RW'(XFER_CYCLES));

    a_r6_busy_from_write: assert property (@(posedge clk) disable iff (rst)
        $rose(ty_busy) |-> $past(bus_we && (bus_addr == OFS_TIME_SET || bus_addr == OFS_YEAR_SET)));

    a_r5_trim_busy_from_write: assert property (@(posedge clk) disable iff (rst)
        $rose(tr_busy) |-> $past(bus_we && bus_addr == OFS_TRIM));

    a_r8_prescaler_restart: assert property (@(posedge clk) disable iff (rst)
        load_time |=> pre_count == '0);

    a_r9_second_holds: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load_time) |=> $stable(cur_sec));

    a_r11_year_steps: assert property (@(posedge clk) disable iff (rst)
        !load_year |=> (year_now == $past(year_now) || year_now == $past(year_now) + YEAR_W'(1)));

endmodule

bind tod_calendar tod_calendar_chk #(.PRESC_W(PRESC_W), .XFER_CYCLES(XFER_CYCLES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .ty_busy   (ty_busy),
    .tr_busy   (tr_busy),
    .load_time (load_time),
    .load_year (load_year),
    .tick      (tick),
    .pre_count (pre_count),
    .cur_sec   (now.second),
    .year_now  (year_now)
);

// File: tb/tod_calendar_bench.sv
module tod_calendar_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TRIM_FAST  = 3;

    localparam logic [7:0] A_TRIM = 8'h00, A_TSET = 8'h04, A_YSET = 8'h08,
                           A_TGET = 8'h0C, A_YGET = 8'h10, A_CTRL = 8'h40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tod_calendar u_tod_calendar (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    typedef struct packed {
        int yr; int mo; int dy; int hr; int mi; int se; int n;
        int eyr; int emo; int edy; int ehr; int emi; int ese;
    } vec_t;

    localparam vec_t VECS [0:8] = '{
        '{1999, 12, 31, 23, 59, 59, 1, 2000,  1,  1,  0,  0,  0},
        '{2000,  2, 28, 23, 59, 59, 1, 2000,  2, 29,  0,  0,  0},
        '{1900,  2, 28, 23, 59, 59, 1, 1900,  3,  1,  0,  0,  0},
        '{2024,  2, 29, 23, 59, 58, 2, 2024,  3,  1,  0,  0,  0},
        '{2023,  4, 30, 23, 59, 59, 1, 2023,  5,  1,  0,  0,  0},
        '{2023,  6, 15, 10, 20, 30, 3, 2023,  6, 15, 10, 20, 33},
        '{2021,  3, 31, 13, 59, 59, 1, 2021,  3, 31, 14,  0,  0},
        '{2100,  2, 28, 23, 59, 59, 1, 2100,  3,  1,  0,  0,  0},
        '{2400,  2, 28, 23, 59, 59, 1, 2400,  2, 29,  0,  0,  0}
    };

    function automatic logic [31:0] pk(int mo, int dy, int hr, int mi, int se);
        return (32'(mo) << 26) | (32'(dy) << 21) | (32'(hr) << 16) |
               (32'(mi) << 10) | (32'(se) << 4);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic peek(logic [7:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic wait_idle(int bitpos);
        logic [31:0] v;
        peek(A_CTRL, v);
        while (v[bitpos]) begin
            @(negedge clk);
            peek(A_CTRL, v);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        logic [31:0] wa;
        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        peek(A_TRIM, v); check("R1 trim", v, 32'd32767);
        peek(A_TGET, v); check("R1 time", v, 32'h0420_0000);
        peek(A_YGET, v); check("R1 year", v, 32'd1900);
        peek(A_CTRL, v); check("R1 busy bits", {30'd0, v[4], v[0]}, 32'd0);
        // R12 running flags
        check("R12 status", {30'd0, v[8], v[5]}, 32'd3);
        // R2 unmapped read
        peek(8'h24, v); check("R2 unmapped", v, 32'd0);

        // R5 trim transfer timing
        bus_write(A_TRIM, TRIM_FAST);
        peek(A_CTRL, v); check("R5 busy first", 32'(v[4]), 32'd1);
        step(3);
        peek(A_CTRL, v); check("R5 busy last", 32'(v[4]), 32'd1);
        peek(A_TRIM, v); check("R5 old trim held", v, 32'd32767);
        step(1);
        peek(A_CTRL, v); check("R5 busy cleared", 32'(v[4]), 32'd0);
        peek(A_TRIM, v); check("R5 trim applied", v, TRIM_FAST);

        // R6 trim write during busy dropped
        bus_write(A_TRIM, 32'd5);
        bus_write(A_TRIM, 32'd9);
        wait_idle(4);
        peek(A_TRIM, v); check("R6 trim second write dropped", v, 32'd5);
        bus_write(A_TRIM, TRIM_FAST);
        wait_idle(4);

        // R4 / R3 / R8 time load
        bus_write(A_YSET, 32'd2023);
        wait_idle(0);
        wa = pk(6, 15, 10, 20, 30);
        bus_write(A_TSET, wa | 32'hF);
        peek(A_CTRL, v); check("R4 busy first", 32'(v[0]), 32'd1);
        step(3);
        peek(A_CTRL, v); check("R4 busy last", 32'(v[0]), 32'd1);
        step(1);
        peek(A_CTRL, v); check("R4 busy cleared", 32'(v[0]), 32'd0);
        peek(A_TGET, v); check("R3 R4 loaded word, low nibble zero", v, wa);
        peek(A_YGET, v); check("R4 year loaded", v, 32'd2023);
        step(TRIM_FAST);
        peek(A_TGET, v); check("R8 no tick before full period", v, wa);
        step(1);
        peek(A_TGET, v); check("R8 R7 first tick", v, pk(6, 15, 10, 20, 31));
        step(TRIM_FAST + 1);
        peek(A_TGET, v); check("R7 second tick", v, pk(6, 15, 10, 20, 32));

        // R6 time and year writes during busy dropped
        wa = pk(8, 8, 8, 8, 8);
        bus_write(A_TSET, wa);
        bus_write(A_TSET, pk(9, 9, 9, 9, 9));
        bus_write(A_YSET, 32'd1234);
        wait_idle(0);
        peek(A_TGET, v); check("R6 time second write dropped", v, wa);
        peek(A_YGET, v); check("R6 year write during busy dropped", v, 32'd2023);

        // R9 R10 R11 rollover table
        for (int i = 0; i < 9; i++) begin
            bus_write(A_YSET, VECS[i].yr);
            wait_idle(0);
            bus_write(A_TSET, pk(VECS[i].mo, VECS[i].dy, VECS[i].hr, VECS[i].mi, VECS[i].se));
            wait_idle(0);
            step(VECS[i].n * (TRIM_FAST + 1));
            peek(A_TGET, v);
            check($sformatf("R9 R10 R11 vector %0d time", i), v,
                  pk(VECS[i].emo, VECS[i].edy, VECS[i].ehr, VECS[i].emi, VECS[i].ese));
            peek(A_YGET, v);
            check($sformatf("R11 vector %0d year", i), v, VECS[i].eyr);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule